// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register File

This block is the control-port register file of an audio codec. It sits on a simple synchronous bus and decodes a 64-byte window as sixteen 32-bit word locations. Word 0 holds an index, and word 1 is a data window onto a bank of thirty-two 8-bit indirect entries. Software first loads the index, then reads or writes word 1 to reach the selected entry.

A few locations follow special rules. One indirect entry can be written but always reads as zero. Two indirect entries are read-only constants. One indirect entry merges a fixed revision code into whatever is written. Word 2 is read-only. Setting the low bit of word 4 soft-resets the whole block in the same cycle as the write. An active-low asynchronous reset gives the same initial state.

Read data is registered. A write and a read in the same cycle perform only the write.

Top module: `codec_ctl_regfile`

## Requirements
- R1: The word number is byte address bits [5:2]. Words 0, 3 and 5 to 15 store and read back the full 32-bit write data.
- R2: The index is word 0 bits [4:0]. A write to word 1 stores wr_data_i[7:0] into the indexed entry. A read of word 1 returns that entry zero-extended to 32 bits.
- R3: Indirect entry 3 stores writes, but a read of it through word 1 always returns 0.
- R4: Writes to indirect entries 11 and 25 are ignored. They keep their reset values 0x00 and 0xA0.
- R5: A write to indirect entry 12 stores (data & 0x40) | 0x8A.
- R6: Word 2 always reads 0, and writes to it are discarded.
- R7: A write to word 4 stores only wr_data_i[6:0]. Bits [31:7] read as 0.
- R8: A write to word 4 with bit 0 set returns every word and entry to its reset value on that same clock edge. Word 4 then holds the written value masked to 7 bits.
- R9: After rst_ni, indirect entry 12 reads 0x8A, entry 25 reads 0xA0, and every other word and entry reads 0.
- R10: rd_data_o is registered. After a clock edge with rd_en_i high and wr_en_i low, it shows the addressed location as it was before that edge. In all other cycles it holds its value. Its reset value is 0.
- R11: When wr_en_i and rd_en_i are high together, the write is performed and rd_data_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address within the window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |

## Verification
The embedded assertions check, on every cycle, several invariants. The revision entry always holds its fixed code bits. The read-only entries never change on a write. The write-only entry never reads as non-zero. Word 4 never holds bits above bit 6. A soft reset clears the index. Read data holds whenever no read is accepted or a write collides with it. Other behaviours can only be shown by the bench's scenarios, because they depend on history. These are the round trip of values through the index/data pair, the full reset image, and the restoration of every location after a soft reset that occurs partway through random traffic. The bench checks these against a reference model.

// File: rtl/codec_regfile_pkg.sv
package codec_regfile_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned WORDS     = 16;
  localparam int unsigned IND_DEPTH = 32;
  localparam int unsigned IDX_W     = $clog2(IND_DEPTH);
  localparam int unsigned IND_W     = 8;

  // direct word roles
  localparam int unsigned W_INDEX  = 0;
  localparam int unsigned W_PORT   = 1;
  localparam int unsigned W_LOCKED = 2;
  localparam int unsigned W_CTRL   = 4;
  localparam int unsigned CTRL_KEEP = 7;

  // indirect entry roles
  localparam int unsigned E_WONLY = 3;
  localparam int unsigned E_RONLY = 11;
  localparam int unsigned E_REV   = 12;
  localparam int unsigned E_ID    = 25;

  localparam logic [IND_W-1:0] REV_CODE = 8'h8A;
  localparam logic [IND_W-1:0] REV_KEEP = 8'h40;
  localparam logic [IND_W-1:0] ID_CODE  = 8'hA0;

  function automatic logic [IND_W-1:0] ind_init(int unsigned e);
    if (e == E_REV) return REV_CODE;
    if (e == E_ID)  return ID_CODE;
    return '0;
  endfunction
endpackage

// File: rtl/codec_direct_regs.sv
module codec_direct_regs
  import codec_regfile_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = WORDS,
  parameter int unsigned IW = IDX_W,
  localparam int unsigned AW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_word_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_word_i,
  output logic          soft_rst_o,
  output logic [IW-1:0] idx_o,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] q [NW];

  assign soft_rst_o = wr_i && (wr_word_i == AW'(W_CTRL)) && wr_data_i[0];

  for (genvar i = 0; i < NW; i++) begin : g_word
    if (i == W_PORT || i == W_LOCKED) begin : g_none
      assign q[i] = '0;
    end else if (i == W_CTRL) begin : g_ctrl
      logic [DW-1:0] r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          r <= '0;
        else if (wr_i && wr_word_i == AW'(i)) r <= {{(DW-CTRL_KEEP){1'b0}}, wr_data_i[CTRL_KEEP-1:0]};
      end
      assign q[i] = r;

      AST_CTRL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r[DW-1:CTRL_KEEP] == '0); // R7
    end else begin : g_rw
      logic [DW-1:0] r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          r <= '0;
        else if (soft_rst_o)                  r <= '0;
        else if (wr_i && wr_word_i == AW'(i)) r <= wr_data_i;
      end
      assign q[i] = r;
    end
  end

  assign idx_o     = q[W_INDEX][IW-1:0];
  assign rd_data_o = q[rd_word_i];

  AST_SOFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (q[W_INDEX] == '0)); // R8
endmodule

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
  import codec_regfile_pkg::*;
#(
  parameter int unsigned DEPTH = IND_DEPTH,
  parameter int unsigned EW    = IND_W,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [EW-1:0] wr_data_i,
  output logic [EW-1:0] rd_data_o
);
  logic [EW-1:0] q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [EW-1:0] r;
    if (e == E_RONLY || e == E_ID) begin : g_ro
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         r <= ind_init(e);
        else if (soft_rst_i) r <= ind_init(e);
      end
    end else if (e == E_REV) begin : g_rev
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        r <= ind_init(e);
        else if (soft_rst_i)                r <= ind_init(e);
        else if (wr_i && idx_i == IW'(e))   r <= (wr_data_i & REV_KEEP) | REV_CODE;
      end
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        r <= ind_init(e);
        else if (soft_rst_i)                r <= ind_init(e);
        else if (wr_i && idx_i == IW'(e))   r <= wr_data_i;
      end
    end
    assign q[e] = r;
  end

  // write-only entry is masked on the read path
  assign rd_data_o = (idx_i == IW'(E_WONLY)) ? '0 : q[idx_i];

  AST_WO_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == IW'(E_WONLY)) |-> (rd_data_o == '0)); // R3
  AST_RO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !soft_rst_i && (idx_i == IW'(E_RONLY) || idx_i == IW'(E_ID)))
      |=> ($stable(q[E_RONLY]) && $stable(q[E_ID]))); // R4
  AST_REV_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q[E_REV] & ~REV_KEEP) == REV_CODE)); // R5
endmodule

// File: rtl/codec_ctl_regfile.sv
module codec_ctl_regfile
  import codec_regfile_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned WW = AW - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o
);
  logic [WW-1:0]    word;
  logic [1:0]       unused_lsb;
  logic             soft_rst;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    dir_rd;
  logic [IND_W-1:0] ind_rd;
  logic             wr_port;
  logic [DW-1:0]    rd_mux;
  logic [DW-1:0]    rd_q;

  assign word       = addr_i[AW-1:2];
  assign unused_lsb = addr_i[1:0];
  assign wr_port    = wr_en_i && (word == WW'(W_PORT));

  codec_direct_regs #(.DW(DW), .NW(1 << WW), .IW(IDX_W)) u_direct (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i),
    .wr_word_i  (word),
    .wr_data_i  (wr_data_i),
    .rd_word_i  (word),
    .soft_rst_o (soft_rst),
    .idx_o      (idx),
    .rd_data_o  (dir_rd)
  );

  codec_indirect_bank #(.DEPTH(IND_DEPTH), .EW(IND_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .wr_i       (wr_port),
    .idx_i      (idx),
    .wr_data_i  (wr_data_i[IND_W-1:0]),
    .rd_data_o  (ind_rd)
  );

  assign rd_mux = (word == WW'(W_PORT)) ? {{(DW-IND_W){1'b0}}, ind_rd} : dir_rd;

  // write wins over a colliding read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rd_q <= '0;
    else if (rd_en_i && !wr_en_i) rd_q <= rd_mux;
  end
  assign rd_data_o = rd_q;

  AST_LOCKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && word == WW'(W_LOCKED)) |=> (rd_data_o == '0)); // R6
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R10
  AST_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && wr_en_i) |=> $stable(rd_data_o)); // R11
endmodule

// File: tb/codec_ctl_regfile_tb.sv
`timescale 1ns/1ps
module codec_ctl_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_dir [16];
  logic [7:0]  m_ind [32];

  always #4 clk = ~clk;

  codec_ctl_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data)
  );

  function automatic void m_reset();
    for (int i = 0; i < 16; i++) m_dir[i] = '0;
    for (int i = 0; i < 32; i++) m_ind[i] = '0;
    m_ind[12] = 8'h8A;
    m_ind[25] = 8'hA0;
  endfunction

  function automatic logic [31:0] m_read(int w);
    int e;
    e = int'(m_dir[0][4:0]);
    if (w == 1) return (e == 3) ? 32'h0 : {24'h0, m_ind[e]};
    if (w == 2) return 32'h0;
    return m_dir[w];
  endfunction

  function automatic void m_write(int w, logic [31:0] d);
    int e;
    e = int'(m_dir[0][4:0]);
    if (w == 1) begin
      if (e == 12) m_ind[e] = (d[7:0] & 8'h40) | 8'h8A;
      else if (e != 11 && e != 25) m_ind[e] = d[7:0];
    end else if (w == 4) begin
      if (d[0]) m_reset();
      m_dir[4] = d & 32'h7F;
    end else if (w != 2) m_dir[w] = d;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(int w, logic [31:0] d);
    @(negedge clk);
    addr = 6'(w << 2); wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(w, d);
  endtask

  task automatic bus_read(int w, string tag);
    logic [31:0] e;
    e = m_read(w);
    @(negedge clk);
    addr = 6'(w << 2); rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rd_data, e);
  endtask

  task automatic read_ind(int e, string tag);
    bus_write(0, 32'(e));
    bus_read(1, tag);
  endtask

  task automatic sweep(string tag);
    for (int w = 0; w < 16; w++) if (w != 1) bus_read(w, tag);
    for (int e = 0; e < 32; e++) read_ind(e, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_reset();
    repeat (3) @(negedge clk);
    chk("R10 reset rd_data", rd_data, 32'h0);
    rst_n = 1'b1;

    // R9 reset image
    sweep("R9");

    // R1 full-width words
    bus_write(3, 32'hDEADBEEF); bus_read(3, "R1");
    bus_write(15, 32'h12345678); bus_read(15, "R1");
    bus_write(0, 32'hFFFF_FFE7); bus_read(0, "R1");

    // R2 data port, upper bits dropped
    bus_write(0, 32'd7); bus_write(1, 32'hABCD_EF5A); bus_read(1, "R2");
    bus_write(0, 32'd31); bus_write(1, 32'h0000_01C3); bus_read(1, "R2");

    // R3 write-only entry
    bus_write(0, 32'd3); bus_write(1, 32'h77); bus_read(1, "R3");

    // R4 read-only entries
    bus_write(0, 32'd11); bus_write(1, 32'hFF); bus_read(1, "R4");
    bus_write(0, 32'd25); bus_write(1, 32'h5); bus_read(1, "R4");

    // R5 merged revision entry
    bus_write(0, 32'd12); bus_write(1, 32'hFF); bus_read(1, "R5");
    bus_write(1, 32'h00); bus_read(1, "R5");

    // R6 read-only word
    bus_write(2, 32'hCAFEF00D); bus_read(2, "R6");

    // R7 masked control word
    bus_write(4, 32'hFFFF_FFFE); bus_read(4, "R7");

    // R10 hold when idle
    bus_read(5, "R10");
    repeat (3) @(negedge clk);
    chk("R10 hold", rd_data, m_read(5));

    // R11 collision: write happens, read dropped
    bus_write(6, 32'h1111_2222);
    bus_read(6, "R11");
    @(negedge clk);
    addr = 6'(7 << 2); wr_data = 32'h3333_4444; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 rd_data unchanged", rd_data, 32'h1111_2222);
    m_write(7, 32'h3333_4444);
    bus_read(7, "R11");

    // R8 soft reset after dirtying state
    bus_write(0, 32'd12); bus_write(1, 32'h40);
    bus_write(0, 32'd9);  bus_write(1, 32'h99);
    bus_write(4, 32'hFFFF_FF81);
    bus_read(4, "R8");
    sweep("R8");

    // random traffic against the model
    for (int n = 0; n < 800; n++) begin
      int w;
      logic [31:0] d;
      w = int'($urandom % 16);
      d = $urandom;
      if (w == 4 && ($urandom % 4) != 0) d[0] = 1'b0;
      if (w == 0) d[4:0] = 5'($urandom % 32);
      if ($urandom % 2) bus_write(w, d);
      else bus_read(w, (w == 1) ? "R2" : "R1");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule